// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block holds a 64-bit accumulator, split into a high word and a low word, and the multiplier datapath that feeds it. Each cycle in which `op_valid` is high it carries out one command chosen by `op_code`. The commands cover plain multiplies that replace either the low word or both words, a clear, and two multiply-accumulate forms. The 16x16 form can saturate to a 32-bit range. The 32x32 form can saturate to a 48-bit range. Saturation is turned on by the `sat_mode` input, which is sampled with the command.

Operands arrive on `opnd_m` and `opnd_n` already fetched. Address arithmetic and memory traffic are the job of the surrounding pipeline. Software-visible moves into the accumulator use the two half-word write strobes. Both halves can always be read on `mac_hi` and `mac_lo`. Every command finishes in a single clock, and its result can be read on the outputs in the next cycle.

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low, both `mac_hi` and `mac_lo` read zero.
- R2: Command 1 writes the low 32 bits of `opnd_m*opnd_n` to the low word. The high word keeps its value.
- R3: Command 2 multiplies the zero-extended bits [15:0] of both operands. Command 3 multiplies the sign-extended bits [15:0] of both operands. Each writes its 32-bit product to the low word and keeps the high word.
- R4: Command 4 writes the full 64-bit unsigned product of the operands to {high, low}. Command 5 writes the full 64-bit signed product to {high, low}.
- R5: Command 6 sets both words to zero.
- R6: Command 7 with `sat_mode` low adds the sign-extended 16x16 signed product to the whole 64-bit accumulator, modulo 2^64.
- R7: Command 7 with `sat_mode` high forms a sum of the signed low word and the signed 16x16 product. When that sum lies within the signed 32-bit range, the sum replaces the low word and the high word is unchanged.
- R8: Command 7 with `sat_mode` high and a sum above 0x7FFFFFFF leaves {high, low} = 0x00000001_7FFFFFFF. With a sum below -0x80000000 it leaves 0x00000001_80000000.
- R9: Command 8 with `sat_mode` low adds the 64-bit signed product of the operands to the accumulator, modulo 2^64.
- R10: Command 8 with `sat_mode` high takes the same modulo-2^64 sum and clamps it, as a signed value, to the range 0xFFFF8000_00000000 to 0x00007FFF_FFFFFFFF.
- R11: With `op_valid` low, `wr_hi` loads `wr_data` into the high word only and `wr_lo` loads it into the low word only. Both strobes may be set together. When `op_valid` is high, both strobes are ignored.
- R12: Command codes 0 and 9 to 15 leave the accumulator unchanged. A cycle with no command and no write strobe also leaves it unchanged. All results appear on the outputs one cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Command strobe |
| op_code | input | 4 | Command select (see R2 to R12) |
| sat_mode | input | 1 | Saturation enable for the accumulate commands |
| opnd_m | input | 32 | First multiplier operand |
| opnd_n | input | 32 | Second multiplier operand |
| wr_hi | input | 1 | Load `wr_data` into the high word |
| wr_lo | input | 1 | Load `wr_data` into the low word |
| wr_data | input | 32 | Data for direct half-word writes |
| mac_hi | output | 32 | High accumulator word |
| mac_lo | output | 32 | Low accumulator word |

## Verification
The accumulator is the only state, and it drives the outputs directly. A wrong update therefore shows on `mac_hi`/`mac_lo` in the very next cycle, and it persists until the next overwrite. The greatest risk is in the quiet paths. A high word that drifts after a low-word-only command stays hidden until an accumulate is carried into it. A clamp boundary that is off by one shows only when a sum lands exactly at the limit. For that reason the stimulus seeds the accumulator with direct writes just beside each limit before each accumulate.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE   = 4'd0,
        OP_MUL_LO = 4'd1,
        OP_MULU16 = 4'd2,
        OP_MULS16 = 4'd3,
        OP_DMULU  = 4'd4,
        OP_DMULS  = 4'd5,
        OP_CLEAR  = 4'd6,
        OP_ACC16  = 4'd7,
        OP_ACC32  = 4'd8
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   opnd_m,
    input  logic [DW-1:0]   opnd_n,
    output logic [DW-1:0]   prod_lo,
    output logic [DW-1:0]   prod_u16,
    output logic [DW-1:0]   prod_s16,
    output logic [2*DW-1:0] prod_u64,
    output logic [2*DW-1:0] prod_s64
);
    localparam int HW = DW / 2;
    localparam int AW = 2 * DW;

    logic [AW-1:0] m_zx, n_zx, m_sx, n_sx;
    logic [DW-1:0] m16_zx, n16_zx, m16_sx, n16_sx;

    always_comb begin
        m_zx   = {{DW{1'b0}}, opnd_m};
        n_zx   = {{DW{1'b0}}, opnd_n};
        m_sx   = {{DW{opnd_m[DW-1]}}, opnd_m};
        n_sx   = {{DW{opnd_n[DW-1]}}, opnd_n};
        m16_zx = {{HW{1'b0}}, opnd_m[HW-1:0]};
        n16_zx = {{HW{1'b0}}, opnd_n[HW-1:0]};
        m16_sx = {{HW{opnd_m[HW-1]}}, opnd_m[HW-1:0]};
        n16_sx = {{HW{opnd_n[HW-1]}}, opnd_n[HW-1:0]};
    end

    // Truncated products of extended operands are exact at these widths.
    always_comb begin
        prod_u64 = m_zx * n_zx;
        prod_s64 = m_sx * n_sx;
        prod_lo  = prod_u64[DW-1:0];
        prod_u16 = m16_zx * n16_zx;
        prod_s16 = m16_sx * n16_sx;
    end

endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
    parameter int DW = 32
) (
    input  logic [2*DW-1:0] acc_q,
    input  logic [DW-1:0]   prod_s16,
    input  logic [2*DW-1:0] prod_s64,
    output logic [2*DW-1:0] acc16_wrap,
    output logic [2*DW-1:0] acc16_sat,
    output logic [2*DW-1:0] acc32_wrap,
    output logic [2*DW-1:0] acc32_sat
);
    localparam int HW     = DW / 2;
    localparam int AW     = 2 * DW;
    localparam int WIDE_W = DW + HW;

    localparam logic signed [AW-1:0] NARROW_MAX =
        {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] NARROW_MIN = ~NARROW_MAX;
    localparam logic signed [AW-1:0] WIDE_MAX =
        {{(AW-WIDE_W+1){1'b0}}, {(WIDE_W-1){1'b1}}};
    localparam logic signed [AW-1:0] WIDE_MIN = ~WIDE_MAX;
    localparam logic [DW-1:0] OVF_HI = {{(DW-1){1'b0}}, 1'b1};

    logic        [AW-1:0] p16_ext;
    logic signed [AW-1:0] lo_sum;
    logic signed [AW-1:0] wide_sum;

    // Narrow path: signed low word plus product, clamped to 32 bits.
    always_comb begin
        p16_ext    = {{DW{prod_s16[DW-1]}}, prod_s16};
        acc16_wrap = acc_q + p16_ext;
        lo_sum     = $signed({{DW{acc_q[DW-1]}}, acc_q[DW-1:0]}) + $signed(p16_ext);
        if (lo_sum > NARROW_MAX) begin
            acc16_sat = {OVF_HI, NARROW_MAX[DW-1:0]};
        end else if (lo_sum < NARROW_MIN) begin
            acc16_sat = {OVF_HI, NARROW_MIN[DW-1:0]};
        end else begin
            acc16_sat = {acc_q[AW-1:DW], lo_sum[DW-1:0]};
        end
    end

    // Wide path: full sum modulo 2^64, clamped to 48 bits when asked.
    always_comb begin
        acc32_wrap = acc_q + prod_s64;
        wide_sum   = $signed(acc32_wrap);
        if (wide_sum > WIDE_MAX) begin
            acc32_sat = WIDE_MAX;
        end else if (wide_sum < WIDE_MIN) begin
            acc32_sat = WIDE_MIN;
        end else begin
            acc32_sat = acc32_wrap;
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic            sat_mode,
    input  logic [DW-1:0]   opnd_m,
    input  logic [DW-1:0]   opnd_n,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   mac_hi,
    output logic [DW-1:0]   mac_lo
);
    localparam int HW = DW / 2;
    localparam int AW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } acc_t;

    acc_t    st_d, st_q;
    mac_op_e op_sel;

    logic [DW-1:0] prod_lo, prod_u16, prod_s16;
    logic [AW-1:0] prod_u64, prod_s64;
    logic [AW-1:0] acc16_wrap, acc16_sat, acc32_wrap, acc32_sat;

    mac_mult #(.DW(DW)) u_mult (
        .opnd_m   (opnd_m),
        .opnd_n   (opnd_n),
        .prod_lo  (prod_lo),
        .prod_u16 (prod_u16),
        .prod_s16 (prod_s16),
        .prod_u64 (prod_u64),
        .prod_s64 (prod_s64)
    );

    mac_acc #(.DW(DW)) u_acc (
        .acc_q      (st_q),
        .prod_s16   (prod_s16),
        .prod_s64   (prod_s64),
        .acc16_wrap (acc16_wrap),
        .acc16_sat  (acc16_sat),
        .acc32_wrap (acc32_wrap),
        .acc32_sat  (acc32_sat)
    );

    always_comb begin
        op_sel = mac_op_e'(op_code);
        st_d   = st_q;
        if (op_valid) begin
            case (op_sel)
                OP_MUL_LO: st_d.lo = prod_lo;
                OP_MULU16: st_d.lo = prod_u16;
                OP_MULS16: st_d.lo = prod_s16;
                OP_DMULU:  st_d    = prod_u64;
                OP_DMULS:  st_d    = prod_s64;
                OP_CLEAR:  st_d    = '0;
                OP_ACC16:  st_d    = sat_mode ? acc16_sat : acc16_wrap;
                OP_ACC32:  st_d    = sat_mode ? acc32_sat : acc32_wrap;
                default:   st_d    = st_q;
            endcase
        end else begin
            if (wr_hi) st_d.hi = wr_data;
            if (wr_lo) st_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mac_hi = st_q.hi;
    assign mac_lo = st_q.lo;

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CLEAR) |=> (mac_hi == '0 && mac_lo == '0));

    // R2
    lowmul_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_MUL_LO || op_code == OP_MULU16 ||
                      op_code == OP_MULS16)) |=> $stable(mac_hi));

    // R8
    narrow_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ACC16 && sat_mode) |=>
        (mac_hi == $past(mac_hi) || mac_hi == {{(DW-1){1'b0}}, 1'b1}));

    // R10
    wide_sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ACC32 && sat_mode) |=>
        (mac_hi[DW-1:HW-1] == '0 || mac_hi[DW-1:HW-1] == '1));

    // R11
    hi_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && wr_hi && !wr_lo) |=>
        (mac_hi == $past(wr_data) && $stable(mac_lo)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !wr_hi && !wr_lo) |=> ($stable(mac_hi) && $stable(mac_lo)));

endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        sat_mode = 1'b0;
    logic [31:0] opnd_m = '0, opnd_n = '0, wr_data = '0;
    logic        wr_hi = 1'b0, wr_lo = 1'b0;
    logic [31:0] mac_hi, mac_lo;

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] model = '0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mac_unit i_mac_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .sat_mode(sat_mode), .opnd_m(opnd_m), .opnd_n(opnd_n),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .mac_hi(mac_hi), .mac_lo(mac_lo)
    );

    task automatic compare(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h_%h expected %h_%h", tag,
                     got[63:32], got[31:0], exp[63:32], exp[31:0]);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Reference model of one cycle, written from the requirements.
    function automatic logic [63:0] next_model(input logic [63:0] cur, input bit v,
        input logic [3:0] op, input bit s, input logic [31:0] a, input logic [31:0] b,
        input bit wh, input bit wl, input logic [31:0] wd);
        logic [63:0] r = cur;
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ha = longint'($signed(a[15:0]));
        longint hb = longint'($signed(b[15:0]));
        longint t;
        if (!v) begin
            if (wh) r[63:32] = wd;
            if (wl) r[31:0]  = wd;
            return r;
        end
        case (op)
            4'd1: r[31:0] = a * b;
            4'd2: r[31:0] = 32'(a[15:0]) * 32'(b[15:0]);
            4'd3: r[31:0] = 32'(ha * hb);
            4'd4: r = {32'd0, a} * {32'd0, b};
            4'd5: r = 64'(sa * sb);
            4'd6: r = '0;
            4'd7: begin
                if (s) begin
                    t = longint'($signed(cur[31:0])) + ha * hb;
                    if (t > 64'sd2147483647)       r = 64'h00000001_7FFFFFFF;
                    else if (t < -64'sd2147483648) r = 64'h00000001_80000000;
                    else                           r[31:0] = t[31:0];
                end else begin
                    r = cur + 64'(ha * hb);
                end
            end
            4'd8: begin
                t = longint'(cur) + sa * sb;
                if (s) begin
                    if (t > 64'sh00007FFF_FFFFFFFF)      t = 64'sh00007FFF_FFFFFFFF;
                    else if (t < 64'shFFFF8000_00000000) t = 64'shFFFF8000_00000000;
                end
                r = 64'(t);
            end
            default: r = cur;
        endcase
        return r;
    endfunction

    task automatic drive(input string tag, input bit v, input logic [3:0] op, input bit s,
        input logic [31:0] a, input logic [31:0] b,
        input bit wh, input bit wl, input logic [31:0] wd);
        @(negedge clk);
        op_valid = v; op_code = op; sat_mode = s; opnd_m = a; opnd_n = b;
        wr_hi = wh; wr_lo = wl; wr_data = wd;
        model = next_model(model, v, op, s, a, b, wh, wl, wd);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic op(input string tag, input logic [3:0] c, input bit s,
                      input logic [31:0] a, input logic [31:0] b);
        drive(tag, 1'b1, c, s, a, b, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic load(input string tag, input logic [31:0] hi, input logic [31:0] lo);
        drive(tag, 1'b0, 4'd0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, hi);
        drive(tag, 1'b0, 4'd0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, lo);
    endtask

    // Monitor: one expected item per driven cycle, checked after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) compare(tag_q.pop_front(), {mac_hi, mac_lo}, exp_q.pop_front());
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset", {mac_hi, mac_lo}, 64'h0);
        rst_n = 1'b1;

        drive("R11 hi only", 1'b0, 4'd0, 1'b0, 0, 0, 1'b1, 1'b0, 32'h12345678);
        drive("R11 lo only", 1'b0, 4'd0, 1'b0, 0, 0, 1'b0, 1'b1, 32'h9ABCDEF0);
        op("R2 mul low", 4'd1, 1'b0, 32'h12345678, 32'h9ABCDEF1);
        op("R3 mulu16", 4'd2, 1'b0, 32'hFFFFFFFF, 32'h1234FFFF);
        op("R3 muls16", 4'd3, 1'b0, 32'hFFFFFFFF, 32'h1234FFFF);
        op("R3 muls16 mixed", 4'd3, 1'b0, 32'h00008000, 32'h00000003);
        op("R4 dmulu", 4'd4, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        op("R4 dmuls", 4'd5, 1'b0, 32'hFFFFFFFF, 32'h00000007);
        op("R5 clear", 4'd6, 1'b0, 32'h0, 32'h0);
        drive("R11 both", 1'b0, 4'd0, 1'b0, 0, 0, 1'b1, 1'b1, 32'h000055AA);
        op("R12 code 11", 4'd11, 1'b1, 32'h7, 32'h9);
        op("R12 code 0", 4'd0, 1'b0, 32'h7, 32'h9);
        drive("R12 idle", 1'b0, 4'd0, 1'b0, 32'h7, 32'h9, 1'b0, 1'b0, 32'hDEAD);
        drive("R11 op wins", 1'b1, 4'd1, 1'b0, 32'h3, 32'h5, 1'b1, 1'b1, 32'hFFFF0000);

        load("R6 seed", 32'h0, 32'hFFFFFFFF);
        op("R6 carry", 4'd7, 1'b0, 32'h1, 32'h1);
        op("R6 negative", 4'd7, 1'b0, 32'h0000FFFF, 32'h00000002);

        load("R7 seed", 32'h0000ABCD, 32'h00000010);
        op("R7 in range", 4'd7, 1'b1, 32'h3, 32'hFFFFFFFE);
        load("R8 seed hi", 32'h00000005, 32'h7FFF0000);
        op("R8 above", 4'd7, 1'b1, 32'h00007FFF, 32'h00007FFF);
        load("R8 seed lo", 32'h00000005, 32'h80000100);
        op("R8 below", 4'd7, 1'b1, 32'h00007FFF, 32'hFFFF8000);
        load("R8 edge", 32'h00000009, 32'h7FFFFFFE);
        op("R8 at max", 4'd7, 1'b1, 32'h1, 32'h1);

        load("R9 seed", 32'hFFFFFFFF, 32'hFFFFFFFF);
        op("R9 wrap", 4'd8, 1'b0, 32'h1, 32'h1);
        op("R9 signed", 4'd8, 1'b0, 32'h80000000, 32'h00000002);

        load("R10 seed hi", 32'h00007FFF, 32'hFFFFFFF0);
        op("R10 clamp max", 4'd8, 1'b1, 32'h10, 32'h10);
        load("R10 seed lo", 32'hFFFF8000, 32'h00000000);
        op("R10 clamp min", 4'd8, 1'b1, 32'hFFFFFFFF, 32'h1);
        op("R10 in range", 4'd8, 1'b1, 32'h2, 32'h3);

        drive("R12 final idle", 1'b0, 4'd0, 1'b0, 0, 0, 1'b0, 1'b0, 0);
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R12 drain: got %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule